// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is ready for ordinary traffic. While it is in charge it keeps clock enable and the data mask lines high and drives no-operation commands for a long start-up wait. It then closes every bank with one precharge command. It programs the mode register and issues a burst of auto-refresh commands, in the order a parameter selects. Every timing limit is given in nanoseconds. It is turned into a whole number of clock cycles at elaboration, rounding any fraction up, and the commands are spaced by those counts with no-operations in between.

Once the last wait has run out the block raises `init_done`. From then on it passes the command, address, bank, clock-enable and mask inputs of a downstream controller straight to the memory pins. Before that point those controller inputs have no effect.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, only NOP commands appear on the pins for the first ceil(PAUSE_NS*1000/CLK_PERIOD_PS) cycles. NOP means cs_n=0, ras_n=1, cas_n=1 and we_n=1, with the address at zero.
- R2: While `init_done` is low, including during reset, `sd_cke` is 1 and every bit of `sd_dqm` is 1.
- R3: The first command after the pause is a precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0). It is issued exactly once, with address bit AP_BIT (10) set, every other address bit clear, and the bank at zero.
- R4: One mode register set is issued (cs_n, ras_n, cas_n and we_n all 0), with MODE_WORD on the address bus and the bank at zero.
- R5: max(REFRESH_COUNT, 8) auto-refresh commands are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1), each with the address and bank at zero.
- R6: When MRS_FIRST=1 the mode register set follows the precharge directly and comes before all refreshes. When MRS_FIRST=0 it follows the last refresh.
- R7: Each command is separated from the previous one by exactly the rounded-up cycle count of the previous command's timing: TRP_NS after a precharge, TMRD_NS after a mode set, TRFC_NS after a refresh. NOP is driven in between.
- R8: `init_done` rises one cycle after the wait that follows the last command expires. It then stays high until the next reset.
- R9: While `init_done` is low, the controller inputs have no effect on any memory pin.
- R10: While `init_done` is high, every memory pin equals the matching controller input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_cs_n | input | 1 | Controller chip select |
| ctl_ras_n | input | 1 | Controller RAS |
| ctl_cas_n | input | 1 | Controller CAS |
| ctl_we_n | input | 1 | Controller write enable |
| ctl_addr | input | ADDR_W | Controller address |
| ctl_ba | input | BA_W | Controller bank address |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_dqm | input | DQM_W | Controller data mask |
| sd_cs_n | output | 1 | Memory chip select |
| sd_ras_n | output | 1 | Memory RAS |
| sd_cas_n | output | 1 | Memory CAS |
| sd_we_n | output | 1 | Memory write enable |
| sd_addr | output | ADDR_W | Memory address |
| sd_ba | output | BA_W | Memory bank address |
| sd_cke | output | 1 | Memory clock enable |
| sd_dqm | output | DQM_W | Memory data mask |
| init_done | output | 1 | Initialization complete, controller owns the bus |

## Verification
The assertions assume that reset is held for at least one clock edge and that the clock runs without gaps. They also assume the controller inputs are known values once `init_done` is high. They make no assumption about controller inputs during initialization, because those inputs must be ignored then. The stimulus therefore drives illegal-looking commands, low clock-enable and zero masks on the controller side throughout the sequence. After completion it drives a changing pattern.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_MRS  = 3'd1,
    ST_REF  = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4
  } step_t;

  // Nanoseconds to clock cycles, any fraction counts as a full cycle.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned period_ps);
    longint unsigned num;
    longint unsigned cyc;
    num = ns * 64'd1000;
    cyc = (num + period_ps - 64'd1) / period_ps;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // A loaded value counts down one per cycle until zero.
  assert_timer_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned RP_CYC    = 2,
  parameter int unsigned MRD_CYC   = 2,
  parameter int unsigned RFC_CYC   = 7,
  parameter int unsigned REF_N     = 8,
  parameter bit          MRS_FIRST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          issue,
  output step_t         step,
  output logic          done
);
  localparam int unsigned RW = width_for(REF_N);

  step_t         step_q, step_d;
  logic [RW-1:0] refs_left, refs_left_d;

  assign issue = expired && (step_q == ST_PRE || step_q == ST_MRS || step_q == ST_REF);

  always_comb begin
    step_d      = step_q;
    refs_left_d = refs_left;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    if (expired) begin
      unique case (step_q)
        ST_PRE: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(RP_CYC - 1);
          step_d   = MRS_FIRST ? ST_MRS : ST_REF;
        end
        ST_MRS: begin
          tmr_load = 1'b1;
          tmr_val  = TW'(MRD_CYC - 1);
          step_d   = MRS_FIRST ? ST_REF : ST_FIN;
        end
        ST_REF: begin
          tmr_load    = 1'b1;
          tmr_val     = TW'(RFC_CYC - 1);
          refs_left_d = refs_left - 1'b1;
          if (refs_left == RW'(1)) step_d = MRS_FIRST ? ST_FIN : ST_MRS;
        end
        ST_FIN:  step_d = ST_DONE;
        default: step_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= ST_PRE;
      refs_left <= RW'(REF_N);
    end else begin
      step_q    <= step_d;
      refs_left <= refs_left_d;
    end
  end

  assign step = step_q;
  assign done = (step_q == ST_DONE);

  // Completion is sticky until reset.
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // A command is only issued while the sequence is still running.
  assert_no_issue_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !issue);
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 2,
  parameter int unsigned AP_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              done,
  input  logic              issue,
  input  step_t             step,
  input  logic              ctl_cs_n,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [BA_W-1:0]   ctl_ba,
  input  logic              ctl_cke,
  input  logic [DQM_W-1:0]  ctl_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm
);
  localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << AP_BIT;

  logic [3:0]        init_cmd;
  logic [ADDR_W-1:0] init_addr;

  always_comb begin
    init_cmd  = 4'b0111;
    init_addr = '0;
    if (issue) begin
      unique case (step)
        ST_PRE: begin init_cmd = 4'b0010; init_addr = PRE_ALL;   end
        ST_MRS: begin init_cmd = 4'b0000; init_addr = MODE_WORD; end
        ST_REF: begin init_cmd = 4'b0001; end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (done) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n};
      sd_addr = ctl_addr;
      sd_ba   = ctl_ba;
      sd_cke  = ctl_cke;
      sd_dqm  = ctl_dqm;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = init_cmd;
      sd_addr = init_addr;
      sd_ba   = '0;
      sd_cke  = 1'b1;
      sd_dqm  = '1;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 7500,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned TRP_NS        = 20,
  parameter int unsigned TRFC_NS       = 70,
  parameter int unsigned TMRD_NS       = 15,
  parameter int unsigned REFRESH_COUNT = 8,
  parameter bit          MRS_FIRST     = 1'b1,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned DQM_W         = 2,
  parameter int unsigned AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_cs_n,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [BA_W-1:0]   ctl_ba,
  input  logic              ctl_cke,
  input  logic [DQM_W-1:0]  ctl_dqm,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  localparam int unsigned PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC    = ns_to_cycles(TRP_NS,   CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC   = ns_to_cycles(TRFC_NS,  CLK_PERIOD_PS);
  localparam int unsigned MRD_CYC   = ns_to_cycles(TMRD_NS,  CLK_PERIOD_PS);
  localparam int unsigned REF_N     = max2(REFRESH_COUNT, 8);
  localparam int unsigned MAX_GAP   = max2(max2(RP_CYC, RFC_CYC), MRD_CYC);
  localparam int unsigned TW        = width_for(max2(PAUSE_CYC, MAX_GAP));
  localparam int unsigned RW        = width_for(REF_N);

  logic          tmr_expired;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          issue;
  step_t         step;
  logic          done;

  sdram_init_timer #(.W(TW), .RST_VAL(PAUSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sdram_init_fsm #(
    .TW(TW), .RP_CYC(RP_CYC), .MRD_CYC(MRD_CYC), .RFC_CYC(RFC_CYC),
    .REF_N(REF_N), .MRS_FIRST(MRS_FIRST)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(tmr_expired), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .issue(issue), .step(step), .done(done)
  );

  sdram_cmd_drive #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE_WORD)
  ) u_drive (
    .done(done), .issue(issue), .step(step),
    .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n),
    .ctl_addr(ctl_addr), .ctl_ba(ctl_ba), .ctl_cke(ctl_cke), .ctl_dqm(ctl_dqm),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_cke(sd_cke), .sd_dqm(sd_dqm)
  );

  assign init_done = done;

  // ---- Named pin-level events for the assertions ----
  wire pin_pre = !init_done && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;
  wire pin_mrs = !init_done && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000;
  wire pin_ref = !init_done && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001;
  wire pin_cmd = pin_pre || pin_mrs || pin_ref;

  logic [TW-1:0] since_rst;
  logic [TW-1:0] since_cmd;
  logic [TW-1:0] need_gap;
  logic          seen_cmd;
  logic [RW-1:0] refs_seen;
  logic [1:0]    mrs_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0;
      since_cmd <= '0;
      need_gap  <= '0;
      seen_cmd  <= 1'b0;
      refs_seen <= '0;
      mrs_seen  <= '0;
    end else begin
      if (since_rst != TW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
      if (pin_cmd) begin
        since_cmd <= TW'(1);
        seen_cmd  <= 1'b1;
        need_gap  <= pin_pre ? TW'(RP_CYC) : pin_mrs ? TW'(MRD_CYC) : TW'(RFC_CYC);
      end else if (since_cmd != TW'(MAX_GAP)) begin
        since_cmd <= since_cmd + 1'b1;
      end
      if (pin_ref && refs_seen != RW'(REF_N)) refs_seen <= refs_seen + 1'b1;
      if (pin_mrs && mrs_seen != 2'd3) mrs_seen <= mrs_seen + 1'b1;
    end
  end

  assert_pause_respected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_cmd |-> (since_rst == TW'(PAUSE_CYC)));
  assert_cke_dqm_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_cke && (&sd_dqm)));
  assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre |-> (sd_addr[AP_BIT] && !seen_cmd && sd_ba == '0));
  assert_mode_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (sd_addr == MODE_WORD && sd_ba == '0));
  assert_refresh_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (refs_seen == RW'(REF_N) && mrs_seen == 2'd1));
  assert_mrs_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (refs_seen == (MRS_FIRST ? RW'(0) : RW'(REF_N))));
  assert_cmd_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && seen_cmd) |-> (since_cmd == need_gap));
  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (sd_addr == ctl_addr && sd_cke == ctl_cke && sd_ras_n == ctl_ras_n));
endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
  localparam int CLK_NS    = 10;
  localparam int PERIOD_PS = CLK_NS * 1000;
  localparam int PAUSE_NS  = 2000;
  localparam int RP_NS     = 20;
  localparam int RFC_NS    = 66;
  localparam int MRD_NS    = 15;
  localparam int NREF      = 8;
  localparam int AW        = 13;
  localparam int BW        = 2;
  localparam int DW        = 2;
  localparam int AP        = 10;
  localparam logic [AW-1:0] MODE = 13'h032;
  localparam int HORIZON   = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_cke;
  logic [AW-1:0] ctl_addr;
  logic [BW-1:0] ctl_ba;
  logic [DW-1:0] ctl_dqm;

  logic [3:0]    o_cmd [2];
  logic [AW-1:0] o_addr[2];
  logic [BW-1:0] o_ba  [2];
  logic          o_cke [2];
  logic [DW-1:0] o_dqm [2];
  logic          o_done[2];

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  sdram_init_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .PAUSE_NS(PAUSE_NS), .TRP_NS(RP_NS), .TRFC_NS(RFC_NS),
    .TMRD_NS(MRD_NS), .REFRESH_COUNT(NREF), .MRS_FIRST(1'b0), .ADDR_W(AW), .BA_W(BW),
    .DQM_W(DW), .AP_BIT(AP), .MODE_WORD(MODE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n),
    .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_addr(ctl_addr), .ctl_ba(ctl_ba),
    .ctl_cke(ctl_cke), .ctl_dqm(ctl_dqm),
    .sd_cs_n(o_cmd[0][3]), .sd_ras_n(o_cmd[0][2]), .sd_cas_n(o_cmd[0][1]), .sd_we_n(o_cmd[0][0]),
    .sd_addr(o_addr[0]), .sd_ba(o_ba[0]), .sd_cke(o_cke[0]), .sd_dqm(o_dqm[0]),
    .init_done(o_done[0])
  );

  sdram_init_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .PAUSE_NS(PAUSE_NS), .TRP_NS(RP_NS), .TRFC_NS(RFC_NS),
    .TMRD_NS(MRD_NS), .REFRESH_COUNT(NREF), .MRS_FIRST(1'b1), .ADDR_W(AW), .BA_W(BW),
    .DQM_W(DW), .AP_BIT(AP), .MODE_WORD(MODE)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n),
    .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_addr(ctl_addr), .ctl_ba(ctl_ba),
    .ctl_cke(ctl_cke), .ctl_dqm(ctl_dqm),
    .sd_cs_n(o_cmd[1][3]), .sd_ras_n(o_cmd[1][2]), .sd_cas_n(o_cmd[1][1]), .sd_we_n(o_cmd[1][0]),
    .sd_addr(o_addr[1]), .sd_ba(o_ba[1]), .sd_cke(o_cke[1]), .sd_dqm(o_dqm[1]),
    .init_done(o_done[1])
  );

  // Reference schedule: command code per cycle index since reset release.
  logic [3:0]    exp_cmd [2][HORIZON];
  logic [AW-1:0] exp_addr[2][HORIZON];
  int            done_at [2];

  function automatic int to_cyc(input int ns);
    return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  endfunction

  task automatic build(input int w, input bit mrs_first);
    int t;
    int q_time[$];
    logic [3:0] q_code[$];
    for (int k = 0; k < HORIZON; k++) begin
      exp_cmd[w][k]  = 4'b0111;
      exp_addr[w][k] = '0;
    end
    t = to_cyc(PAUSE_NS);
    q_time.push_back(t); q_code.push_back(4'b0010); t += to_cyc(RP_NS);
    if (mrs_first) begin q_time.push_back(t); q_code.push_back(4'b0000); t += to_cyc(MRD_NS); end
    for (int i = 0; i < NREF; i++) begin
      q_time.push_back(t); q_code.push_back(4'b0001); t += to_cyc(RFC_NS);
    end
    if (!mrs_first) begin q_time.push_back(t); q_code.push_back(4'b0000); t += to_cyc(MRD_NS); end
    done_at[w] = t + 1;
    while (q_time.size() > 0) begin
      int tt;
      logic [3:0] cc;
      tt = q_time.pop_front();
      cc = q_code.pop_front();
      exp_cmd[w][tt] = cc;
      exp_addr[w][tt] = (cc == 4'b0010) ? (AW'(1) << AP) : (cc == 4'b0000) ? MODE : '0;
    end
  endtask

  task automatic check(input int w, input int k, input bit in_reset);
    logic [3:0] ec;
    logic [AW-1:0] ea;
    logic [BW-1:0] eb;
    logic ek, ed;
    logic [DW-1:0] em;
    string tag;
    if (!in_reset && k >= done_at[w]) begin
      ec = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n};
      ea = ctl_addr; eb = ctl_ba; ek = ctl_cke; em = ctl_dqm; ed = 1'b1;
      tag = (k == done_at[w]) ? "R8 done rise" : "R10 passthrough";
    end else begin
      ec = in_reset ? 4'b0111 : exp_cmd[w][k];
      ea = in_reset ? '0 : exp_addr[w][k];
      eb = '0; ek = 1'b1; em = '1; ed = 1'b0;
      if (in_reset) tag = "R2 reset state";
      else if (ec == 4'b0010) tag = "R3 precharge-all";
      else if (ec == 4'b0000) tag = "R4 mode set, R6 order";
      else if (ec == 4'b0001) tag = "R5 refresh, R7 spacing";
      else if (k < to_cyc(PAUSE_NS)) tag = "R1 pause NOP, R9 inputs ignored";
      else tag = "R7 gap NOP, R8 not done yet";
    end
    checks++;
    if (o_cmd[w] !== ec || o_addr[w] !== ea || o_ba[w] !== eb || o_cke[w] !== ek ||
        o_dqm[w] !== em || o_done[w] !== ed) begin
      fails++;
      $display("FAIL %s dut%0d cycle %0d: got cmd=%b addr=%h ba=%h cke=%b dqm=%b done=%b exp cmd=%b addr=%h ba=%h cke=%b dqm=%b done=%b",
               tag, w, k, o_cmd[w], o_addr[w], o_ba[w], o_cke[w], o_dqm[w], o_done[w],
               ec, ea, eb, ek, em, ed);
    end
  endtask

  task automatic drive_ctl(input int k, input bit after);
    if (!after) begin
      // Hostile values during init: looks like a mode set, CKE and mask low.
      {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n} = 4'b0000;
      ctl_addr = AW'(13'h1abc ^ k);
      ctl_ba = 2'b11; ctl_cke = 1'b0; ctl_dqm = '0;
    end else begin
      {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n} = 4'(k * 5 + 3);
      ctl_addr = AW'(k * 37);
      ctl_ba = BW'(k); ctl_cke = k[0]; ctl_dqm = DW'(k >> 1);
    end
  endtask

  initial begin
    build(0, 1'b0);
    build(1, 1'b1);
    drive_ctl(0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(0, 0, 1'b1);
    check(1, 0, 1'b1);
    rst_n = 1'b1;
    for (int k = 1; k < done_at[0] + 30 && k < HORIZON; k++) begin
      @(negedge clk);
      check(0, k, 1'b0);
      check(1, k, 1'b0);
      drive_ctl(k, (k + 1 >= done_at[0]) && (k + 1 >= done_at[1]));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule